// File: doc/BRIEF.md
# Sector Hamming Code Generator and Checker

This block computes a 24-bit single-error-correcting parity code over one sector of bytes. The bytes arrive one per clock. A start pulse opens each sector and picks a direction. In generate mode, the block folds every byte into two parity halves. After the final byte it sends the packed, inverted code out as a short byte stream, least significant byte first.

In check mode the sector is streamed in the same way, followed by the code bytes that were stored with it. The block then compares the recomputed code with the stored one and classifies the result:

- clean;
- a single data bit in error, reported with its byte and bit position;
- a single bit in error inside the stored code;
- uncorrectable.

Flipping the reported data bit in the sector buffer is the job of the surrounding logic.

Each bit of the sector has a 12-bit position: the byte index in the upper nine bits and the bit index in the lower three. For every position bit, one half of the code holds the parity of the data bits whose position has that bit clear. The other half holds the parity of the data bits whose position has it set. A single flipped data bit therefore changes the two halves by exact complements of each other. The half that tracks set bits then carries the error position directly.

Top module: `hm_ecc_sector`

## Requirements
- R1: After reset, `done` and `enc_valid` are low and `chk_status` is 2'b00.
- R2: In generate mode (`check_mode`=0), the code is computed from the accepted bytes only. Let P be the 12-bit position (byte index × 8 + bit index) of a data bit that is 1. The lower half is the XOR of ~P over all such bits, and the upper half is the XOR of P. The packed word is {upper, lower}, and the emitted code is its bitwise inverse. It appears on `enc_byte` for exactly three consecutive cycles, least significant byte first. The first code byte appears in the cycle after the last sector byte is accepted, and `done` is high in that cycle only.
- R3: An all-0xFF sector yields code bytes FF, FF, FF. Checking that sector against the stored code FF FF FF reports clean.
- R4: In check mode, `done` pulses for one cycle, one cycle after the third stored code byte is accepted (bytes least significant first). A mismatch of zero reports `chk_status` 2'b00.
- R5: A mismatch whose upper 12 bits XOR its lower 12 bits equals 0xFFF reports 2'b01 (data bit fixed). In that case `err_byte` is mismatch bits 23:15 and `err_bit` is mismatch bits 14:12.
- R6: A mismatch with exactly one bit set reports 2'b10 (code bit in error). `err_byte` and `err_bit` are zero whenever the status is not 2'b01.
- R7: Any other nonzero mismatch reports 2'b11 (uncorrectable).
- R8: A complementary mismatch whose byte index is not below `SECTOR_BYTES` reports 2'b11.
- R9: `start` clears the parity and counters and abandons any sector in progress. A byte presented in the same cycle as `start` is not taken, and `done` and `enc_valid` are low in the cycle after `start`.
- R10: The block ignores the following inputs:
  - data bytes presented after the sector is complete;
  - code bytes presented during the data phase, in generate mode, or after a check has finished.

  No code burst is produced in check mode, and `chk_status` is 2'b00 after a generate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Opens a new sector and latches `check_mode` |
| check_mode | input | 1 | 0 = generate code, 1 = check against stored code |
| data_valid | input | 1 | Sector byte present |
| data_byte | input | 8 | Sector byte |
| code_valid | input | 1 | Stored code byte present (check mode) |
| code_byte | input | 8 | Stored code byte, least significant first |
| done | output | 1 | One-cycle end-of-sector strobe |
| enc_valid | output | 1 | Generated code byte present |
| enc_byte | output | 8 | Generated code byte |
| chk_status | output | 2 | 00 clean, 01 data fix, 10 code bit, 11 uncorrectable |
| err_byte | output | 9 | Byte index of the bad data bit |
| err_bit | output | 3 | Bit index of the bad data bit |

## Verification
The bound checker watches several properties on every cycle:
- the quiet cycle after `start`;
- that `done` never lasts two cycles;
- that a code burst begins with `done` and lasts three cycles;
- that no burst appears in check mode;
- that the error fields are zero unless a data fix is reported, and that a reported byte index lies inside the sector.

The bench scenarios cover the rest: the actual parity values, the erased-sector code, the classification of chosen mismatch patterns, the out-of-range byte index on a 384-byte instance, and the handling of ignored bytes.

// File: rtl/hm_ecc_pkg.sv
// Shared types for the sector Hamming code generator/checker.
// Assumes: result encodings are visible at the top ports as raw 2-bit values.
package hm_ecc_pkg;
    typedef enum logic [1:0] {
        CHK_CLEAN    = 2'b00,
        CHK_FIX_DATA = 2'b01,
        CHK_FIX_CODE = 2'b10,
        CHK_BAD      = 2'b11
    } chk_status_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_DATA = 2'b01,
        PH_CODE = 2'b10
    } phase_e;
endpackage

// File: rtl/hm_parity_acc.sv
// Parity accumulator: folds one byte per cycle into two parity halves.
// Bit k of hi is the parity of data bits whose 12-bit position has bit k set;
// bit k of lo covers positions with bit k clear. Position = {byte addr, bit idx}.
// Assumes: clr has priority over take; addr is the byte index of din.
module hm_parity_acc #(
    parameter int ADDR_W = 9,
    localparam int HW    = ADDR_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [HW-1:0]     par_lo,
    output logic [HW-1:0]     par_hi
);
    logic [HW-1:0] upd_lo;
    logic [HW-1:0] upd_hi;
    logic          byte_par;

    // Per-byte contribution of din to both halves.
    always_comb begin
        upd_lo   = '0;
        upd_hi   = '0;
        byte_par = ^din;
        for (int k = 0; k < 3; k++) begin
            for (int b = 0; b < 8; b++) begin
                if (((b >> k) & 1) == 1) upd_hi[k] = upd_hi[k] ^ din[b];
                else                     upd_lo[k] = upd_lo[k] ^ din[b];
            end
        end
        for (int j = 0; j < ADDR_W; j++) begin
            upd_hi[j+3] = addr[j] & byte_par;
            upd_lo[j+3] = ~addr[j] & byte_par;
        end
    end

    // Accumulate contributions; cleared at sector start.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            par_lo <= '0;
            par_hi <= '0;
        end else if (take) begin
            par_lo <= par_lo ^ upd_lo;
            par_hi <= par_hi ^ upd_hi;
        end
    end
endmodule

// File: rtl/hm_code_ser.sv
// Code serializer: sends a code word out as NB bytes, least significant first,
// one per cycle, starting the cycle after kick.
// Assumes: code_word is stable for the whole burst; abort ends a burst at once.
module hm_code_ser #(
    parameter int CW = 24,
    parameter int NB = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          kick,
    input  logic [CW-1:0] code_word,
    output logic          ser_valid,
    output logic [7:0]    ser_byte
);
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;

    logic [IW-1:0]   idx;
    logic            active;
    logic [NB*8-1:0] padded;

    // Zero-extend the code word to whole bytes.
    always_comb begin
        padded            = '0;
        padded[CW-1:0]    = code_word;
    end

    assign ser_valid = active;
    assign ser_byte  = padded[8*int'(idx) +: 8];

    // Burst sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (kick) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (active) begin
            if (idx == IW'(NB - 1)) begin
                active <= 1'b0;
                idx    <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hm_syndrome_eval.sv
// Syndrome evaluator: classifies the mismatch between recomputed and stored code.
// Assumes: both codes are in the same (inverted) form, so the inversion cancels.
module hm_syndrome_eval
    import hm_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int ADDR_W       = 9,
    localparam int HW          = ADDR_W + 3,
    localparam int CW          = 2 * HW
) (
    input  logic [CW-1:0]     calc_code,
    input  logic [CW-1:0]     stored_code,
    output logic [1:0]        status,
    output logic [ADDR_W-1:0] err_byte,
    output logic [2:0]        err_bit
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(SECTOR_BYTES);

    logic [CW-1:0] mism;
    logic [HW-1:0] m_lo;
    logic [HW-1:0] m_hi;
    logic          is_comp;
    logic          is_single;
    logic          in_range;

    assign mism      = calc_code ^ stored_code;
    assign m_lo      = mism[HW-1:0];
    assign m_hi      = mism[CW-1:HW];
    assign is_comp   = &(m_lo ^ m_hi);
    assign is_single = (mism != '0) && ((mism & (mism - CW'(1))) == '0);
    assign in_range  = {1'b0, m_hi[HW-1:3]} < LIMIT;

    // Classification with error position only for a data fix.
    always_comb begin
        status   = CHK_BAD;
        err_byte = '0;
        err_bit  = '0;
        if (mism == '0) begin
            status = CHK_CLEAN;
        end else if (is_comp) begin
            if (in_range) begin
                status   = CHK_FIX_DATA;
                err_byte = m_hi[HW-1:3];
                err_bit  = m_hi[2:0];
            end
        end else if (is_single) begin
            status = CHK_FIX_CODE;
        end
    end
endmodule

// File: rtl/hm_ctrl.sv
// Sector sequencer: counts sector bytes, collects stored code bytes,
// raises the end-of-sector strobe and kicks the code serializer.
// Assumes: start wins over any byte presented in the same cycle.
module hm_ctrl
    import hm_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int ADDR_W       = 9,
    parameter int NB           = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_in,
    input  logic              data_valid,
    input  logic              code_valid,
    input  logic [7:0]        code_byte,
    output logic              acc_clr,
    output logic              acc_take,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [NB*8-1:0]   stored_code,
    output logic              ser_kick,
    output logic              done,
    output logic              rd_q
);
    localparam int CIW                   = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(SECTOR_BYTES - 1);
    localparam logic [CIW-1:0]    LAST_C = CIW'(NB - 1);

    phase_e            phase;
    logic [ADDR_W-1:0] cnt_data;
    logic [CIW-1:0]    cnt_code;
    logic              code_take;
    logic              last_data;
    logic              last_code;

    assign acc_clr   = start;
    assign acc_take  = (phase == PH_DATA) && data_valid && !start;
    assign acc_addr  = cnt_data;
    assign last_data = acc_take && (cnt_data == LAST_A);
    assign code_take = (phase == PH_CODE) && code_valid && !start;
    assign last_code = code_take && (cnt_code == LAST_C);
    assign ser_kick  = last_data && !rd_q;

    // End-of-sector strobe, one cycle after the final accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (last_data && !rd_q) || last_code;
    end

    // Phase, counters and stored-code capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            cnt_data    <= '0;
            cnt_code    <= '0;
            stored_code <= '0;
            rd_q        <= 1'b0;
        end else if (start) begin
            phase       <= PH_DATA;
            cnt_data    <= '0;
            cnt_code    <= '0;
            stored_code <= '0;
            rd_q        <= mode_in;
        end else begin
            if (acc_take) begin
                if (last_data) begin
                    cnt_data <= '0;
                    phase    <= rd_q ? PH_CODE : PH_IDLE;
                end else begin
                    cnt_data <= cnt_data + 1'b1;
                end
            end
            if (code_take) begin
                stored_code[8*int'(cnt_code) +: 8] <= code_byte;
                if (last_code) begin
                    cnt_code <= '0;
                    phase    <= PH_IDLE;
                end else begin
                    cnt_code <= cnt_code + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hm_ecc_sector.sv
// Top: sector Hamming code generator and checker.
// Generate mode streams out the inverted packed code; check mode classifies
// the mismatch against the stored code. Result ports read zero after a generate.
// Assumes: one byte per cycle at most; start opens every sector.
module hm_ecc_sector #(
    parameter int SECTOR_BYTES = 512,
    localparam int ADDR_W      = $clog2(SECTOR_BYTES),
    localparam int HW          = ADDR_W + 3,
    localparam int CW          = 2 * HW,
    localparam int NB          = (CW + 7) / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              check_mode,
    input  logic              data_valid,
    input  logic [7:0]        data_byte,
    input  logic              code_valid,
    input  logic [7:0]        code_byte,
    output logic              done,
    output logic              enc_valid,
    output logic [7:0]        enc_byte,
    output logic [1:0]        chk_status,
    output logic [ADDR_W-1:0] err_byte,
    output logic [2:0]        err_bit
);
    logic              acc_clr;
    logic              acc_take;
    logic [ADDR_W-1:0] acc_addr;
    logic [HW-1:0]     par_lo;
    logic [HW-1:0]     par_hi;
    logic [NB*8-1:0]   stored_code;
    logic              ser_kick;
    logic              rd_q;
    logic [CW-1:0]     calc_code;
    logic [1:0]        ev_status;
    logic [ADDR_W-1:0] ev_byte;
    logic [2:0]        ev_bit;

    hm_ctrl #(
        .SECTOR_BYTES(SECTOR_BYTES),
        .ADDR_W      (ADDR_W),
        .NB          (NB)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode_in    (check_mode),
        .data_valid (data_valid),
        .code_valid (code_valid),
        .code_byte  (code_byte),
        .acc_clr    (acc_clr),
        .acc_take   (acc_take),
        .acc_addr   (acc_addr),
        .stored_code(stored_code),
        .ser_kick   (ser_kick),
        .done       (done),
        .rd_q       (rd_q)
    );

    hm_parity_acc #(.ADDR_W(ADDR_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .take  (acc_take),
        .addr  (acc_addr),
        .din   (data_byte),
        .par_lo(par_lo),
        .par_hi(par_hi)
    );

    assign calc_code = ~{par_hi, par_lo};

    hm_code_ser #(.CW(CW), .NB(NB)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (start),
        .kick     (ser_kick),
        .code_word(calc_code),
        .ser_valid(enc_valid),
        .ser_byte (enc_byte)
    );

    hm_syndrome_eval #(
        .SECTOR_BYTES(SECTOR_BYTES),
        .ADDR_W      (ADDR_W)
    ) u_eval (
        .calc_code  (calc_code),
        .stored_code(stored_code[CW-1:0]),
        .status     (ev_status),
        .err_byte   (ev_byte),
        .err_bit    (ev_bit)
    );

    assign chk_status = rd_q ? ev_status : 2'b00;
    assign err_byte   = rd_q ? ev_byte   : '0;
    assign err_bit    = rd_q ? ev_bit    : '0;
endmodule

// File: rtl/hm_ecc_sector_chk.sv
// Checker for hm_ecc_sector: cycle properties on strobes, bursts and result
// fields. Attached to every instance of the top by the bind below.
module hm_ecc_sector_chk #(
    parameter int SECTOR_BYTES = 512,
    parameter int ADDR_W       = 9,
    parameter int NB           = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic              enc_valid,
    input logic [1:0]        chk_status,
    input logic [ADDR_W-1:0] err_byte,
    input logic [2:0]        err_bit,
    input logic              rd_q
);
    logic [7:0] run_q;

    // Length of the current or just-ended code burst.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= '0;
        else if (enc_valid) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    a_r9_quiet_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && !enc_valid));

    a_r4_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_burst_opens_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enc_valid) |-> done);

    a_r2_burst_length: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(enc_valid) && !$past(start)) |-> (run_q == 8'(NB)));

    a_r10_no_burst_in_check: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid |-> !rd_q);

    a_r10_status_zero_after_generate: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rd_q) |-> (chk_status == 2'b00));

    a_r6_fields_zero_unless_fix: assert property (@(posedge clk) disable iff (!rst_n)
        (done && chk_status != 2'b01) |-> (err_byte == '0 && err_bit == '0));

    a_r8_fix_inside_sector: assert property (@(posedge clk) disable iff (!rst_n)
        (done && chk_status == 2'b01) |-> ({1'b0, err_byte} < (ADDR_W + 1)'(SECTOR_BYTES)));
endmodule

bind hm_ecc_sector hm_ecc_sector_chk #(
    .SECTOR_BYTES(SECTOR_BYTES),
    .ADDR_W      (ADDR_W),
    .NB          (NB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .enc_valid (enc_valid),
    .chk_status(chk_status),
    .err_byte  (err_byte),
    .err_bit   (err_bit),
    .rd_q      (rd_q)
);

// File: tb/tb_hm_ecc_sector.sv
module tb_hm_ecc_sector;
    localparam int CLK_PERIOD = 10;
    localparam int NV         = 8;

    localparam logic [7:0]  V_SEED  [NV] = '{8'd1, 8'd3, 8'd5, 8'd7, 8'd9, 8'd11, 8'd13, 8'd15};
    localparam int          V_FLIP  [NV] = '{-1, 0, 4095, 1603, -1, -1, -1, 81};
    localparam logic [23:0] V_CMASK [NV] = '{24'h0, 24'h0, 24'h0, 24'h0,
                                            24'h000800, 24'h800000, 24'h000003, 24'h000001};
    localparam logic [1:0]  V_STAT  [NV] = '{2'b00, 2'b01, 2'b01, 2'b01,
                                            2'b10, 2'b10, 2'b11, 2'b11};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, check_mode = 1'b0;
    logic data_valid = 1'b0, code_valid = 1'b0;
    logic [7:0] data_byte = '0, code_byte = '0;

    logic done, enc_valid;
    logic [7:0] enc_byte;
    logic [1:0] chk_status;
    logic [8:0] err_byte;
    logic [2:0] err_bit;

    logic s_done, s_enc_valid;
    logic [7:0] s_enc_byte;
    logic [1:0] s_status;
    logic [8:0] s_err_byte;
    logic [2:0] s_err_bit;

    int checks = 0;
    int errors = 0;
    logic [7:0] mem [0:511];

    always #(CLK_PERIOD / 2) clk = ~clk;

    hm_ecc_sector dut (
        .clk(clk), .rst_n(rst_n), .start(start), .check_mode(check_mode),
        .data_valid(data_valid), .data_byte(data_byte),
        .code_valid(code_valid), .code_byte(code_byte),
        .done(done), .enc_valid(enc_valid), .enc_byte(enc_byte),
        .chk_status(chk_status), .err_byte(err_byte), .err_bit(err_bit)
    );

    hm_ecc_sector #(.SECTOR_BYTES(384)) dut_short (
        .clk(clk), .rst_n(rst_n), .start(start), .check_mode(check_mode),
        .data_valid(data_valid), .data_byte(data_byte),
        .code_valid(code_valid), .code_byte(code_byte),
        .done(s_done), .enc_valid(s_enc_valid), .enc_byte(s_enc_byte),
        .chk_status(s_status), .err_byte(s_err_byte), .err_bit(s_err_bit)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected code from the requirement: XOR of ~P (low) and P (high), inverted.
    function automatic logic [23:0] model_code(input int n);
        logic [11:0] lo = '0;
        logic [11:0] hi = '0;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (mem[i][b]) begin
                    lo = lo ^ ~12'(i * 8 + b);
                    hi = hi ^ 12'(i * 8 + b);
                end
            end
        end
        return ~{hi, lo};
    endfunction

    task automatic fill(input logic [7:0] seed);
        for (int i = 0; i < 512; i++) mem[i] = 8'((i * 7) + (seed * 13) + (i >> 3));
    endtask

    task automatic do_start(input logic mode);
        @(negedge clk); start = 1'b1; check_mode = mode;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic feed_range(input int lo, input int hi);
        for (int i = lo; i < hi; i++) begin
            @(negedge clk); data_valid = 1'b1; data_byte = mem[i];
        end
        @(negedge clk); data_valid = 1'b0;
    endtask

    task automatic feed_code(input logic [23:0] c);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); code_valid = 1'b1; code_byte = c[8*k +: 8];
        end
        @(negedge clk); code_valid = 1'b0;
    endtask

    // Called at the sample point right after the last sector byte.
    task automatic grab_code(output logic [23:0] c);
        check_eq("R2 done with first code byte", {31'd0, done}, 32'd1);
        for (int k = 0; k < 3; k++) begin
            if (k > 0) @(negedge clk);
            check_eq("R2 enc_valid in burst", {31'd0, enc_valid}, 32'd1);
            c[8*k +: 8] = enc_byte;
        end
        @(negedge clk);
        check_eq("R2 burst ends after three bytes", {31'd0, enc_valid}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] gold, got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 done after reset", {31'd0, done}, 32'd0);
        check_eq("R1 enc_valid after reset", {31'd0, enc_valid}, 32'd0);
        check_eq("R1 status after reset", {30'd0, chk_status}, 32'd0);

        // Table walk: generate, then check with flips / code masks (R2 R4-R7)
        for (int v = 0; v < NV; v++) begin
            fill(V_SEED[v]);
            gold = model_code(512);
            do_start(1'b0);
            feed_range(0, 512);
            grab_code(got);
            check_eq("R2 generated code", {8'd0, got}, {8'd0, gold});
            if (V_FLIP[v] >= 0) mem[V_FLIP[v] >> 3][V_FLIP[v] & 7] = ~mem[V_FLIP[v] >> 3][V_FLIP[v] & 7];
            do_start(1'b1);
            feed_range(0, 512);
            check_eq("R4 no done before code bytes", {31'd0, done}, 32'd0);
            feed_code(gold ^ V_CMASK[v]);
            check_eq("R4 done after code bytes", {31'd0, done}, 32'd1);
            check_eq("R5 R6 R7 status", {30'd0, chk_status}, {30'd0, V_STAT[v]});
            if (V_STAT[v] == 2'b01) begin
                check_eq("R5 err_byte", {23'd0, err_byte}, 32'(V_FLIP[v] >> 3));
                check_eq("R5 err_bit", {29'd0, err_bit}, 32'(V_FLIP[v] & 7));
            end else begin
                check_eq("R6 fields zero", {20'd0, err_byte, err_bit}, 32'd0);
            end
        end

        // R3 erased sector
        for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
        do_start(1'b0);
        feed_range(0, 512);
        grab_code(got);
        check_eq("R3 erased code", {8'd0, got}, 32'h00FFFFFF);
        do_start(1'b1);
        feed_range(0, 512);
        feed_code(24'hFFFFFF);
        check_eq("R3 erased check clean", {30'd0, chk_status}, 32'd0);

        // R9 abandoned sector and byte in start cycle
        fill(8'd40);
        gold = model_code(512);
        do_start(1'b0);
        feed_range(0, 100);
        @(negedge clk); start = 1'b1; check_mode = 1'b0; data_valid = 1'b1; data_byte = 8'h5A;
        @(negedge clk); start = 1'b0; data_valid = 1'b0;
        check_eq("R9 quiet after start", {30'd0, done, enc_valid}, 32'd0);
        feed_range(0, 512);
        grab_code(got);
        check_eq("R9 code ignores abandoned bytes", {8'd0, got}, {8'd0, gold});

        // R10 bytes in idle after generate are ignored
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); data_valid = 1'b1; code_valid = 1'b1; data_byte = 8'(i); code_byte = 8'hC3;
        end
        @(negedge clk); data_valid = 1'b0; code_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check_eq("R10 idle bytes ignored", {30'd0, done, enc_valid}, 32'd0);
            @(negedge clk);
        end

        // R10 stray code byte in data phase and extra data bytes are ignored
        do_start(1'b1);
        feed_range(0, 256);
        @(negedge clk); code_valid = 1'b1; code_byte = 8'hAB;
        @(negedge clk); code_valid = 1'b0;
        feed_range(256, 512);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); data_valid = 1'b1; data_byte = 8'hE7;
        end
        @(negedge clk); data_valid = 1'b0;
        feed_code(gold);
        check_eq("R10 done after stray bytes", {31'd0, done}, 32'd1);
        check_eq("R10 stray bytes ignored, clean", {30'd0, chk_status}, 32'd0);
        @(negedge clk); code_valid = 1'b1; code_byte = 8'h00;
        @(negedge clk); code_valid = 1'b0;
        check_eq("R10 late code byte ignored", {31'd0, done}, 32'd0);

        // R8 out-of-range byte index on a 384-byte sector
        fill(8'd21);
        gold = model_code(384);
        do_start(1'b0);
        feed_range(0, 384);
        check_eq("R2 short done", {31'd0, s_done}, 32'd1);
        got[7:0] = s_enc_byte;
        @(negedge clk); got[15:8] = s_enc_byte;
        @(negedge clk); got[23:16] = s_enc_byte;
        check_eq("R2 short code", {8'd0, got}, {8'd0, gold});
        do_start(1'b1);
        feed_range(0, 384);
        feed_code(gold ^ {12'hC82, 12'h37D});
        check_eq("R8 index 400 uncorrectable", {30'd0, s_status}, 32'd3);
        do_start(1'b1);
        feed_range(0, 384);
        feed_code(gold ^ {12'hBFD, 12'h402});
        check_eq("R8 index 383 fixable", {30'd0, s_status}, 32'd1);
        check_eq("R8 index 383 byte", {23'd0, s_err_byte}, 32'd383);
        check_eq("R8 index 383 bit", {29'd0, s_err_bit}, 32'd5);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule